// File: doc/BRIEF.md
# Status-Polling Ready Waiter

This controller waits for a target's memory controller to report that it is ready. After a start pulse it repeatedly issues a one-byte status-load command to a serial transceiver. It then takes back exactly one response byte and tests a ready bit in that byte. The wait ends with success as soon as the bit is seen. It ends with failure once a millisecond timeout has run out.

The timeout is counted from a millisecond tick input. The count is cleared when a run begins and saturates at its limit. The limit is tested only when a poll comes back not ready. A response that carries the ready bit therefore wins, even if the limit has already passed. The command byte sits on a valid/ready output stream. Responses arrive on a single-cycle valid input.

Top module: `status_ready_poller`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `success` and `cmd_valid` are all 0.
- R2: Every command byte offered on `cmd_data` is the load opcode OR-ed with the status index, which is 8'h80 with the default parameters.
- R3: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid` stays 1 and `cmd_data` does not change.
- R4: After a command is accepted (`cmd_valid` and `cmd_ready` both 1 at a clock edge), `cmd_valid` stays 0 until a response byte has been taken on `rsp_valid`.
- R5: A response with the ready bit set (mask 8'h02, bit 1) makes `done` and `success` 1 in the cycle after the response. The other bits of the response are ignored, so 8'hFD counts as not ready.
- R6: A not-ready response that arrives while the timeout has not expired makes `cmd_valid` 1 again in the cycle after the response.
- R7: Once the timeout count has reached the limit of `TIMEOUT_MS` ticks, the next not-ready response ends the run with `done`=1 and `success`=0. The count never exceeds the limit.
- R8: Accepting a start clears the timeout count. Ticks that arrive while idle are not counted.
- R9: `done` is high for exactly one cycle. `success` keeps its value until the next start is accepted, and `busy` is 1 from the cycle after start until the cycle in which `done` rises.
- R10: A start pulse that arrives while a run is in progress is ignored. The run continues, and its timeout count is not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a wait run (taken only when idle) |
| ms_tick | input | 1 | One-cycle pulse per elapsed millisecond |
| cmd_data | output | 8 | Command byte to the transceiver |
| cmd_valid | output | 1 | Command byte is offered |
| cmd_ready | input | 1 | Transceiver accepts the command byte |
| rsp_data | input | 8 | Response byte from the transceiver |
| rsp_valid | input | 1 | Response byte present this cycle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| success | output | 1 | Result of the last run: ready bit seen |

## Verification
Two cases are hard to bring about from the ports. One is a response that carries the ready bit after the timeout has already saturated. The other is a start pulse landing mid-run, which would reset the count if it were not ignored. The bench drives a target model. That model places a chosen number of millisecond ticks between each accepted command and its reply, so the count at every decision point is known exactly. Vectors with several ticks per poll push the count past the limit before a ready reply. A directed run pulses start together with a tick during the second poll. The run then has to fail in the same poll as it would without that pulse.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } srp_state_e;
endpackage

// File: rtl/srp_timer.sv
module srp_timer #(
  parameter int LIMIT = 100,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  input  logic tick,
  output logic expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (run && tick && (cnt_q < CW'(LIMIT))) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = (cnt_q >= CW'(LIMIT));

  // R7: saturating count never passes the limit
  a_r7_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(LIMIT));

  // R8: an accepted start leaves the count at zero
  a_r8_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clear |=> (cnt_q == '0));

  // R8: nothing advances the count while idle
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!run && !clear) |=> $stable(cnt_q));
endmodule

// File: rtl/srp_fsm.sv
module srp_fsm
  import srp_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] CMD_BYTE = 8'h80,
  parameter logic [DW-1:0] READY_MASK = 8'h02
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          expired,
  output logic          tmr_clear,
  output logic [DW-1:0] cmd_data,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  input  logic [DW-1:0] rsp_data,
  input  logic          rsp_valid,
  output logic          busy,
  output logic          done,
  output logic          success
);
  srp_state_e state_q;
  logic       rsp_ready_bit;

  assign rsp_ready_bit = |(rsp_data & READY_MASK);
  assign tmr_clear     = start && (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cmd_valid <= 1'b0;
      cmd_data  <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      success   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q   <= ST_SEND;
            cmd_valid <= 1'b1;
            cmd_data  <= CMD_BYTE;
            busy      <= 1'b1;
            success   <= 1'b0;
          end
        end
        ST_SEND: begin
          if (cmd_ready) begin
            state_q   <= ST_WAIT;
            cmd_valid <= 1'b0;
          end
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            if (rsp_ready_bit) begin
              state_q <= ST_IDLE;
              done    <= 1'b1;
              success <= 1'b1;
              busy    <= 1'b0;
            end else if (expired) begin
              state_q <= ST_IDLE;
              done    <= 1'b1;
              success <= 1'b0;
              busy    <= 1'b0;
            end else begin
              state_q   <= ST_SEND;
              cmd_valid <= 1'b1;
              cmd_data  <= CMD_BYTE;
            end
          end
        end
        default: begin
          state_q   <= ST_IDLE;
          cmd_valid <= 1'b0;
          busy      <= 1'b0;
        end
      endcase
    end
  end

  // R3: an offered command is held steady under backpressure
  a_r3_hold_cmd: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));

  // R4: after a handshake, no new command until a response arrives
  a_r4_one_rsp: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_valid);

  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: a start during a run neither ends nor restarts it
  a_r10_ignore_start: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done));
endmodule

// File: rtl/status_ready_poller.sv
module status_ready_poller #(
  parameter int          DW         = 8,
  parameter logic [7:0]  LOAD_OP    = 8'h80,
  parameter logic [7:0]  STATUS_IDX = 8'h00,
  parameter logic [7:0]  READY_MASK = 8'h02,
  parameter int          TIMEOUT_MS = 100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          ms_tick,
  output logic [DW-1:0] cmd_data,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  input  logic [DW-1:0] rsp_data,
  input  logic          rsp_valid,
  output logic          busy,
  output logic          done,
  output logic          success
);
  localparam logic [DW-1:0] CMD_BYTE = DW'(LOAD_OP | STATUS_IDX);
  localparam logic [DW-1:0] MASK     = DW'(READY_MASK);

  logic tmr_clear;
  logic tmr_expired;

  srp_timer #(.LIMIT(TIMEOUT_MS)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clear   (tmr_clear),
    .run     (busy),
    .tick    (ms_tick),
    .expired (tmr_expired)
  );

  srp_fsm #(.DW(DW), .CMD_BYTE(CMD_BYTE), .READY_MASK(MASK)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .expired   (tmr_expired),
    .tmr_clear (tmr_clear),
    .cmd_data  (cmd_data),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .rsp_data  (rsp_data),
    .rsp_valid (rsp_valid),
    .busy      (busy),
    .done      (done),
    .success   (success)
  );

  // R5: a successful finish follows a response carrying the ready bit
  a_r5_success_src: assert property (@(posedge clk) disable iff (rst)
    (done && success) |-> $past(rsp_valid && ((rsp_data & MASK) != '0)));

  // R1: nothing is pending or reported after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !done && !cmd_valid));
endmodule

// File: tb/status_ready_poller_test.sv
module status_ready_poller_test;
  localparam int LIMIT = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       ms_tick = 1'b0;
  logic [7:0] cmd_data;
  logic       cmd_valid;
  logic       cmd_ready = 1'b1;
  logic [7:0] rsp_data = 8'h00;
  logic       rsp_valid = 1'b0;
  logic       busy, done, success;

  int n_checks = 0;
  int n_fails  = 0;

  always #2 clk = ~clk;

  status_ready_poller #(.TIMEOUT_MS(LIMIT)) uut (
    .clk(clk), .rst(rst), .start(start), .ms_tick(ms_tick),
    .cmd_data(cmd_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .rsp_data(rsp_data), .rsp_valid(rsp_valid),
    .busy(busy), .done(done), .success(success)
  );

  // fields: not-ready polls [19:16], ticks per poll [15:8], ready byte [7:0]
  localparam int NV = 7;
  localparam logic [19:0] VEC [NV] = '{
    {4'd0, 8'd0, 8'h02},
    {4'd3, 8'd1, 8'hFF},
    {4'd5, 8'd1, 8'h02},
    {4'd2, 8'd2, 8'h02},
    {4'd1, 8'd3, 8'h03},
    {4'd0, 8'd5, 8'h02},
    {4'd6, 8'd0, 8'h06}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit model(input int nrdy, input int tpp, output int polls);
    int cnt = 0;
    for (int i = 1; i < 64; i++) begin
      cnt = (cnt + tpp > LIMIT) ? LIMIT : cnt + tpp;
      if (i > nrdy) begin polls = i; return 1'b1; end
      if (cnt >= LIMIT) begin polls = i; return 1'b0; end
    end
    polls = 0;
    return 1'b0;
  endfunction

  task automatic run_poll(input int nrdy, input int tpp, input logic [7:0] rdy,
                          input bit mid_start);
    int polls = 0;
    int exp_polls;
    bit exp_succ;
    bit fin = 0;
    exp_succ = model(nrdy, tpp, exp_polls);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(busy == 1'b1, "R9 busy after start", busy, 1);
    while (!fin) begin
      while (!cmd_valid) @(negedge clk);
      check(cmd_data == 8'h80, "R2 command byte", cmd_data, 8'h80);
      @(negedge clk);
      polls++;
      check(cmd_valid == 1'b0, "R4 no command while awaiting reply", cmd_valid, 0);
      for (int t = 0; t < tpp; t++) begin
        ms_tick = 1'b1;
        if (mid_start && polls == 2 && t == 0) start = 1'b1;
        @(negedge clk);
        ms_tick = 1'b0;
        start = 1'b0;
      end
      @(negedge clk);
      check(cmd_valid == 1'b0, "R4 still idle before reply", cmd_valid, 0);
      rsp_valid = 1'b1;
      rsp_data  = (polls > nrdy) ? rdy : 8'hFD;
      @(negedge clk);
      rsp_valid = 1'b0;
      if (done) begin
        fin = 1;
        check(success == exp_succ, "R5/R7 result", success, exp_succ);
        check(polls == exp_polls, "R6/R7 poll count", polls, exp_polls);
        check(busy == 1'b0, "R9 busy drops with done", busy, 0);
        @(negedge clk);
        check(done == 1'b0, "R9 done one cycle", done, 0);
        check(success == exp_succ, "R9 success held", success, exp_succ);
      end else begin
        check(cmd_valid == 1'b1, "R6 next poll issued", cmd_valid, 1);
        if (polls > 40) begin
          check(1'b0, "R7 run did not end", polls, exp_polls);
          fin = 1;
        end
      end
    end
  endtask

  initial begin
    #(4 * 150000);
    check(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(busy == 0 && done == 0 && success == 0 && cmd_valid == 0,
          "R1 reset state", {busy, done, success, cmd_valid}, 0);

    for (int v = 0; v < NV; v++)
      run_poll(int'(VEC[v][19:16]), int'(VEC[v][15:8]), VEC[v][7:0], 1'b0);

    // R8: idle ticks ignored and count restarts (previous run ended saturated)
    run_poll(5, 2, 8'h02, 1'b0);
    repeat (10) begin ms_tick = 1'b1; @(negedge clk); ms_tick = 1'b0; end
    run_poll(3, 1, 8'h02, 1'b0);

    // R10: start during a run neither restarts it nor clears the count
    run_poll(5, 1, 8'h02, 1'b1);

    // R3: backpressure holds the command
    cmd_ready = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check(cmd_valid == 1'b1, "R3 valid held", cmd_valid, 1);
      check(cmd_data == 8'h80, "R3 data stable", cmd_data, 8'h80);
      @(negedge clk);
    end
    cmd_ready = 1'b1;
    @(negedge clk);
    check(cmd_valid == 1'b0, "R3 accepted after ready", cmd_valid, 0);
    rsp_valid = 1'b1; rsp_data = 8'h02;
    @(negedge clk);
    rsp_valid = 1'b0;
    check(done == 1'b1 && success == 1'b1, "R5 ready after backpressure",
          {done, success}, 3);
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule